// File: doc/BRIEF.md
# Line-Frequency Clock Lock Error Detector

This block counts the system clock ticks that fall between successive line-period markers. A line-period marker is one pulse per line cycle, taken from zero-crossing detection. At each marker the count is compared with a fixed target of 33 ticks. When the count is off target the block sends a one-cycle request to the system clock generator: lengthen the tick period when there were too many ticks, shorten it when there were too few. Over many line cycles the tick train settles into a fixed phase relationship with the line waveform. At the nominal 2 kHz tick rate one tick is 0.5 ms.

Requests are produced only when three conditions hold together: three-terminal operation is selected, line current is present, and this channel is the one chosen to steer the lock. Whenever any of them is missing, both requests stay low, the lock streak is dropped, and measurement must re-arm. The block also raises a locked flag after four back-to-back periods that hit the target exactly. The tick counter saturates, so a lost marker cannot make a long period wrap around to a value that looks small.

Top module: `lineLockDetect`

## Requirements
- R1: While reset is asserted and in the first cycle after it, incPeriodReq, decPeriodReq and lockedOut are all low.
- R2: When an evaluated period holds more than 33 ticks, incPeriodReq is high for exactly the one cycle after the marker edge, and decPeriodReq stays low.
- R3: When an evaluated period holds fewer than 33 ticks, decPeriodReq is high for exactly the one cycle after the marker edge, and incPeriodReq stays low.
- R4: When an evaluated period holds exactly 33 ticks, neither request is raised.
- R5: A period is evaluated only if threeTermMode, currentPresent and chanSelected are all high at its closing marker. Otherwise both requests stay low and lockedOut is low.
- R6: The first marker after reset, or after the enable condition of R5 returns, only starts a period. It raises no request and does not count toward lock.
- R7: lockedOut goes high in the cycle after the fourth consecutive evaluated period of exactly 33 ticks. It stays high while further exact periods follow. A mismatching period or a loss of the R5 condition clears it in the same cycle that any request is raised.
- R8: The tick count saturates at 63. A period of 63 or more ticks, for example 97, is treated as 63 and raises incPeriodReq.
- R9: A tick in the same cycle as the closing marker counts toward the period that marker ends.
- R10: incPeriodReq and decPeriodReq are never high together, and each is raised only in the cycle right after a marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickIn | input | 1 | One-cycle pulse per system clock tick |
| periodMark | input | 1 | One-cycle pulse per line-frequency period |
| currentPresent | input | 1 | Line current is present |
| chanSelected | input | 1 | This channel is the one chosen to steer the lock |
| threeTermMode | input | 1 | Three-terminal operation is selected |
| incPeriodReq | output | 1 | One-cycle request to lengthen the tick period |
| decPeriodReq | output | 1 | One-cycle request to shorten the tick period |
| lockedOut | output | 1 | Four consecutive exact periods have been seen |

## Verification
The bench aims at counts of 32, 33 and 34 ticks, where a comparator off by one would give the wrong sign or call an off-target period locked. It runs a period of 97 ticks: a counter that wraps instead of saturating would read that as exactly 33 and report lock. It also runs a tick placed on the marker cycle, which a design that drops it would mark as short. Other cases drop each gating input in turn and check the first marker after re-enable: a design that keeps its arming state would issue a request from a stale, partial count, and one that keeps its streak would report lock too early.

// File: rtl/lineLockPkg.sv
package lineLockPkg;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic restartCount;
    logic bumpStreak;
    logic clearStreak;
  } dpStrobes_t;

  // Comparison of the closing period count against the target
  typedef struct packed {
    logic above;
    logic below;
    logic exact;
  } cmpFlags_t;

endpackage

// File: rtl/lineLockDatapath.sv
module lineLockDatapath
  import lineLockPkg::*;
#(
  parameter int CNT_W        = 6,
  parameter int TARGET       = 33,
  parameter int LOCK_PERIODS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  dpStrobes_t strobes,
  output cmpFlags_t  cmpFlags,
  output logic       streakFull
);

  localparam int STREAK_W = $clog2(LOCK_PERIODS + 1);
  localparam logic [CNT_W-1:0]    CNT_MAX    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]    TGT        = CNT_W'(TARGET);
  localparam logic [STREAK_W-1:0] STREAK_TOP = STREAK_W'(LOCK_PERIODS);

  logic [CNT_W-1:0]    tickCnt;
  logic [CNT_W-1:0]    measured;
  logic [STREAK_W-1:0] streak;

  // Saturating count including a tick in the current cycle
  always_comb begin
    if (tickIn && tickCnt != CNT_MAX) measured = tickCnt + 1'b1;
    else                              measured = tickCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     tickCnt <= '0;
    else if (strobes.restartCount) tickCnt <= '0;
    else                           tickCnt <= measured;
  end

  assign cmpFlags.above = measured > TGT;
  assign cmpFlags.below = measured < TGT;
  assign cmpFlags.exact = measured == TGT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   streak <= '0;
    else if (strobes.clearStreak) streak <= '0;
    else if (strobes.bumpStreak && streak != STREAK_TOP) streak <= streak + 1'b1;
  end

  assign streakFull = (streak == STREAK_TOP);

endmodule

// File: rtl/lineLockControl.sv
module lineLockControl
  import lineLockPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       periodMark,
  input  logic       currentPresent,
  input  logic       chanSelected,
  input  logic       threeTermMode,
  input  cmpFlags_t  cmpFlags,
  output dpStrobes_t strobes,
  output logic       incReq,
  output logic       decReq
);

  logic enable;
  logic armed;
  logic evalNow;

  assign enable  = threeTermMode & currentPresent & chanSelected;
  assign evalNow = periodMark & enable & armed;

  always_comb begin
    strobes.restartCount = periodMark;
    strobes.bumpStreak   = evalNow & cmpFlags.exact;
    strobes.clearStreak  = ~enable | (evalNow & ~cmpFlags.exact);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      incReq <= 1'b0;
      decReq <= 1'b0;
    end else begin
      armed  <= enable & (armed | periodMark);
      incReq <= evalNow & cmpFlags.above;
      decReq <= evalNow & cmpFlags.below;
    end
  end

endmodule

// File: rtl/lineLockDetect.sv
module lineLockDetect
  import lineLockPkg::*;
#(
  parameter int CNT_W        = 6,
  parameter int TARGET       = 33,
  parameter int LOCK_PERIODS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickIn,
  input  logic periodMark,
  input  logic currentPresent,
  input  logic chanSelected,
  input  logic threeTermMode,
  output logic incPeriodReq,
  output logic decPeriodReq,
  output logic lockedOut
);

  dpStrobes_t strobes;
  cmpFlags_t  cmpFlags;

  lineLockControl i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .periodMark     (periodMark),
    .currentPresent (currentPresent),
    .chanSelected   (chanSelected),
    .threeTermMode  (threeTermMode),
    .cmpFlags       (cmpFlags),
    .strobes        (strobes),
    .incReq         (incPeriodReq),
    .decReq         (decPeriodReq)
  );

  lineLockDatapath #(
    .CNT_W        (CNT_W),
    .TARGET       (TARGET),
    .LOCK_PERIODS (LOCK_PERIODS)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tickIn     (tickIn),
    .strobes    (strobes),
    .cmpFlags   (cmpFlags),
    .streakFull (lockedOut)
  );

endmodule

// File: rtl/lineLockChecker.sv
module lineLockChecker (
  input logic clk,
  input logic rstN,
  input logic periodMark,
  input logic currentPresent,
  input logic chanSelected,
  input logic threeTermMode,
  input logic incPeriodReq,
  input logic decPeriodReq,
  input logic lockedOut
);

  logic enIn;
  assign enIn = threeTermMode & currentPresent & chanSelected;

  p_req_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(incPeriodReq && decPeriodReq));

  p_req_after_mark_r2: assert property (@(posedge clk) disable iff (!rstN)
    (incPeriodReq || decPeriodReq) |-> $past(periodMark));

  p_req_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    (incPeriodReq || decPeriodReq) |-> $past(enIn));

  p_lock_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    lockedOut |-> $past(enIn));

  p_lock_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (incPeriodReq || decPeriodReq) |-> !lockedOut);

endmodule

bind lineLockDetect lineLockChecker i_chk (
  .clk            (clk),
  .rstN           (rstN),
  .periodMark     (periodMark),
  .currentPresent (currentPresent),
  .chanSelected   (chanSelected),
  .threeTermMode  (threeTermMode),
  .incPeriodReq   (incPeriodReq),
  .decPeriodReq   (decPeriodReq),
  .lockedOut      (lockedOut)
);

// File: tb/test_lineLockDetect.sv
`timescale 1ns/1ps
module test_lineLockDetect;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0;
  logic periodMark = 1'b0;
  logic currentPresent = 1'b0;
  logic chanSelected = 1'b0;
  logic threeTermMode = 1'b0;
  logic incPeriodReq, decPeriodReq, lockedOut;

  int checks = 0;
  int fails = 0;

  // Bench model state
  bit modelArmed = 1'b0;
  int modelStreak = 0;

  always #2 clk = ~clk;

  lineLockDetect i_lineLockDetect (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .periodMark(periodMark),
    .currentPresent(currentPresent), .chanSelected(chanSelected),
    .threeTermMode(threeTermMode), .incPeriodReq(incPeriodReq),
    .decPeriodReq(decPeriodReq), .lockedOut(lockedOut)
  );

  function automatic int dirOf(int cnt);
    int sat;
    sat = (cnt > 63) ? 63 : cnt;
    if (sat > 33) return 1;
    if (sat < 33) return -1;
    return 0;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // One line period: ticks spread out, then a marker (optionally with a tick)
  task automatic runPeriod(int ticks, bit markTick, bit tt, bit cp, bit cs, string tag);
    bit en;
    int total;
    int expInc, expDec;
    en = tt & cp & cs;
    @(negedge clk);
    threeTermMode = tt; currentPresent = cp; chanSelected = cs;
    for (int i = 0; i < ticks; i++) begin
      @(negedge clk); tickIn = 1'b1;
      @(negedge clk); tickIn = 1'b0;
    end
    @(negedge clk); periodMark = 1'b1; tickIn = markTick;
    @(negedge clk); periodMark = 1'b0; tickIn = 1'b0;
    total = ticks + (markTick ? 1 : 0);
    expInc = 0; expDec = 0;
    if (en) begin
      if (modelArmed) begin
        expInc = (dirOf(total) == 1) ? 1 : 0;
        expDec = (dirOf(total) == -1) ? 1 : 0;
        if (dirOf(total) == 0) modelStreak = (modelStreak < 4) ? modelStreak + 1 : 4;
        else modelStreak = 0;
      end
      modelArmed = 1'b1;
    end else begin
      modelArmed = 1'b0;
      modelStreak = 0;
    end
    check({tag, " inc"}, int'(incPeriodReq), expInc);
    check({tag, " dec"}, int'(decPeriodReq), expDec);
    check({tag, " locked R7"}, int'(lockedOut), (modelStreak >= 4) ? 1 : 0);
    @(negedge clk);
    check({tag, " pulse width R10"}, int'(incPeriodReq | decPeriodReq), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seedSink;
    seedSink = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    check("R1 reset inc", int'(incPeriodReq), 0);
    check("R1 reset dec", int'(decPeriodReq), 0);
    check("R1 reset locked", int'(lockedOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", int'(incPeriodReq | decPeriodReq | lockedOut), 0);

    // R6: first marker only arms, even with a wildly off count
    runPeriod(10, 0, 1, 1, 1, "R6 arm");
    runPeriod(33, 0, 1, 1, 1, "R4 exact1");
    runPeriod(33, 0, 1, 1, 1, "R4 exact2");
    runPeriod(33, 0, 1, 1, 1, "R4 exact3");
    runPeriod(33, 0, 1, 1, 1, "R7 exact4");
    runPeriod(33, 0, 1, 1, 1, "R7 exact5");
    runPeriod(34, 0, 1, 1, 1, "R2 over");
    runPeriod(32, 0, 1, 1, 1, "R3 under");
    runPeriod(97, 0, 1, 1, 1, "R8 wrap97");
    runPeriod(63, 0, 1, 1, 1, "R8 sat63");
    runPeriod(32, 1, 1, 1, 1, "R9 markTick");
    // R5: each gating input dropped in turn
    runPeriod(40, 0, 0, 1, 1, "R5 noThreeTerm");
    runPeriod(20, 0, 1, 1, 1, "R6 rearm1");
    runPeriod(40, 0, 1, 0, 1, "R5 noCurrent");
    runPeriod(20, 0, 1, 1, 1, "R6 rearm2");
    runPeriod(40, 0, 1, 1, 0, "R5 notSelected");
    runPeriod(50, 0, 1, 1, 1, "R6 rearm3");
    for (int k = 0; k < 4; k++) runPeriod(33, 0, 1, 1, 1, "R7 relock");
    runPeriod(33, 0, 1, 0, 1, "R5 lockDrop");

    // Constrained random periods
    for (int n = 0; n < 120; n++) begin
      int ticks;
      bit tt, cp, cs, mt;
      ticks = 30 + int'($urandom % 7);
      if ($urandom % 8 == 0) ticks = int'($urandom % 80);
      tt = 1'b1; cp = 1'b1; cs = 1'b1;
      if ($urandom % 6 == 0) begin
        tt = 1'($urandom); cp = 1'($urandom); cs = 1'($urandom);
      end
      mt = ($urandom % 4 == 0);
      runPeriod(ticks, mt, tt, cp, cs, "R2 R3 R4 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule